// File: doc/BRIEF.md
# Multiply-Accumulate Unit with High/Low Result Pair

This block is the integer multiply engine of a RISC pipeline. It keeps a 64-bit accumulator split into a high word and a low word. A single issue port takes an operation code, a signed/unsigned select and two 32-bit operands. Three of the multiply forms write the high/low pair: a plain multiply loads it, multiply-add adds the product to it and multiply-subtract subtracts the product from it. A fourth form, multiply-to-register, returns only the low 32 bits of the product on the writeback port and leaves the pair untouched. Two move operations return the high word or the low word on the same writeback port.

The engine has a 17-bit-wide multiplier on the second operand. When that operand fits in 16 bits, one pass produces the product. Otherwise, two passes are run, one for the low half and one for the high half, and the partial result is kept between them. This is why both the latency and the issue interval shrink for small operands. `issueReady` tells the pipeline whether the operation it presents can be taken at the next rising edge. A read of the high or low word waits until every earlier multiply has retired, so a read always returns the updated value.

Top module: `mac_hilo_unit`

## Requirements
- R1: An operation is accepted at a rising edge where `issueValid` and `issueReady` are both high. The `issueOp` codes are: 0 multiply, 1 multiply-add, 2 multiply-subtract, 3 multiply-to-register, 4 read high, 5 read low. Codes 6 and 7 are always ready, are accepted and change nothing.
- R2: A multiply loads the full 64-bit product of `opA` and `opB` into the pair, with the upper 32 bits in the high word. `isSigned`=1 treats both operands as two's complement; `isSigned`=0 treats them as unsigned.
- R3: Multiply-add replaces the pair with pair + product. Multiply-subtract replaces it with pair − product. Both use 64-bit arithmetic that wraps around.
- R4: If `opB` is short and an accumulator-form or multiply-to-register operation is accepted at edge n, then another multiply-form operation is ready in the cycle after edge n. An accumulator-form result is in the pair after edge n+1.
- R5: If `opB` is not short, the next multiply-form operation is not ready in the cycle after edge n and becomes ready in the cycle after edge n+1. An accumulator-form result is in the pair after edge n+2.
- R6: `opB` is short when `opB` lies in −32768..32767 with `isSigned`=1, or in 0..65535 with `isSigned`=0.
- R7: Multiply-to-register accepted at edge n drives `wbValid` high with the low 32 bits of the product on `wbData`. This happens in the cycle after edge n+2 (short `opB`) or edge n+3 (otherwise), for one cycle. The high/low pair is unchanged.
- R8: A read-high or read-low operation accepted at edge e drives `wbValid` high with that word on `wbData` in the cycle after edge e, for one cycle. `wbValid` is low in every other cycle.
- R9: A read is not ready while any earlier multiply-form operation is unfinished, or while a multiply-to-register result has not yet appeared on the writeback port.
- R10: After reset both words are zero, `wbValid` is low and every operation code is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An operation is presented |
| issueOp | input | 3 | Operation code |
| isSigned | input | 1 | 1 = signed operands, 0 = unsigned |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand; its size sets the timing |
| issueReady | output | 1 | The presented operation can be taken at the next edge |
| wbValid | output | 1 | `wbData` carries a result this cycle |
| wbData | output | 32 | Result of a read or of multiply-to-register |

## Verification
Some internal faults show up on `issueReady` immediately. These include a wrong pass counter, a wrong short-operand decision or a stuck busy flag. The ready output then differs from the R4/R5/R9 timing within one cycle of the issue, and a reference model evaluated every cycle catches that. A corrupted partial product or accumulator does not show at the ports until a read is issued. For that reason, the stimulus follows every few multiply forms with reads of both words, so a wrong accumulator appears on `wbData` within a few cycles. A wrong multiply-to-register write shows up either as a pair value changed on a later read or as a writeback in the wrong cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef logic [2:0] macOp_t;

  localparam macOp_t OP_MULT = 3'd0;
  localparam macOp_t OP_MADD = 3'd1;
  localparam macOp_t OP_MSUB = 3'd2;
  localparam macOp_t OP_MULR = 3'd3;
  localparam macOp_t OP_MFHI = 3'd4;
  localparam macOp_t OP_MFLO = 3'd5;

  // which slice of the second operand feeds the multiplier this cycle
  typedef enum logic [1:0] {
    PASS_FULL = 2'd0,
    PASS_LOW  = 2'd1,
    PASS_HIGH = 2'd2
  } passSel_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_ADD  = 2'd2,
    ACC_SUB  = 2'd3
  } accMode_e;

  typedef struct packed {
    passSel_e passSel;
    logic     loadOps;
    logic     savePartial;
    accMode_e accMode;
    logic     mulrCapture;
    logic     wbFromPipe;
    logic     moveHi;
    logic     moveLo;
  } macStrobe_t;

endpackage

// File: rtl/mac_size_detect.sv
module mac_size_detect #(
  parameter int W    = 32,
  parameter int HALF = W / 2
) (
  input  logic [W-1:0] opB,
  input  logic         isSigned,
  output logic         fitsHalf
);

  localparam int SIGN_SPAN = W - HALF + 1;

  logic [SIGN_SPAN-1:0] signBits;
  logic                 signedFits;
  logic                 unsignedFits;

  always_comb begin
    signBits     = opB[W-1:HALF-1];
    signedFits   = (&signBits) | ~(|signBits);
    unsignedFits = ~(|opB[W-1:HALF]);
    fitsHalf     = isSigned ? signedFits : unsignedFits;
  end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  macOp_t     issueOp,
  input  logic       fitsHalf,
  output logic       issueReady,
  output macStrobe_t strobe,
  output logic       wbValid
);

  logic   busy;
  logic   slowOp;
  logic   phaseHigh;
  logic   pipeValid;
  macOp_t curOp;

  logic isMulFam;
  logic isMove;
  logic midSlow;
  logic accept;

  always_comb begin
    isMulFam = (issueOp <= OP_MULR);
    isMove   = (issueOp == OP_MFHI) || (issueOp == OP_MFLO);
    midSlow  = busy && slowOp && !phaseHigh;

    if (isMulFam)    issueReady = !midSlow;
    else if (isMove) issueReady = !busy && !pipeValid;
    else             issueReady = 1'b1;

    accept = issueValid && issueReady;

    strobe            = '0;
    strobe.loadOps    = accept && isMulFam;
    strobe.moveHi     = accept && (issueOp == OP_MFHI);
    strobe.moveLo     = accept && (issueOp == OP_MFLO);
    strobe.wbFromPipe = pipeValid;

    if (busy) begin
      if (midSlow) begin
        strobe.passSel     = PASS_LOW;
        strobe.savePartial = 1'b1;
      end else begin
        strobe.passSel = slowOp ? PASS_HIGH : PASS_FULL;
        case (curOp)
          OP_MULT: strobe.accMode = ACC_SET;
          OP_MADD: strobe.accMode = ACC_ADD;
          OP_MSUB: strobe.accMode = ACC_SUB;
          default: strobe.mulrCapture = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      slowOp    <= 1'b0;
      phaseHigh <= 1'b0;
      curOp     <= OP_MULT;
      pipeValid <= 1'b0;
      wbValid   <= 1'b0;
    end else begin
      if (strobe.loadOps) begin
        busy      <= 1'b1;
        slowOp    <= !fitsHalf;
        phaseHigh <= 1'b0;
        curOp     <= issueOp;
      end else if (midSlow) begin
        phaseHigh <= 1'b1;
      end else if (busy) begin
        busy <= 1'b0;
      end
      pipeValid <= strobe.mulrCapture;
      wbValid   <= pipeValid || strobe.moveHi || strobe.moveLo;
    end
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int W    = 32,
  parameter int HALF = W / 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         isSigned,
  input  macStrobe_t   strobe,
  output logic [W-1:0] wbData
);

  localparam int AW   = W + 1;
  localparam int BW   = HALF + 1;
  localparam int PW   = AW + BW;
  localparam int ACCW = 2 * W;

  logic [W-1:0]    aReg;
  logic [W-1:0]    bReg;
  logic            signedReg;
  logic [ACCW-1:0] partial;
  logic [W-1:0]    hiReg;
  logic [W-1:0]    loReg;
  logic [W-1:0]    pipeData;

  logic [AW-1:0]          aExt;
  logic [BW-1:0]          bSlice;
  logic signed [PW-1:0]   prodNarrow;
  logic [ACCW-1:0]        prodWide;
  logic [ACCW-1:0]        total;
  logic [ACCW-1:0]        accNow;
  logic [ACCW-1:0]        accNext;

  always_comb begin
    aExt = {signedReg & aReg[W-1], aReg};
    case (strobe.passSel)
      PASS_LOW:  bSlice = {1'b0, bReg[HALF-1:0]};
      PASS_HIGH: bSlice = {signedReg & bReg[W-1], bReg[W-1:HALF]};
      default:   bSlice = bReg[HALF:0];
    endcase
    prodNarrow = $signed(aExt) * $signed(bSlice);
    prodWide   = {{(ACCW-PW){prodNarrow[PW-1]}}, prodNarrow};
    total      = (strobe.passSel == PASS_HIGH) ? partial + (prodWide << HALF) : prodWide;

    accNow = {hiReg, loReg};
    case (strobe.accMode)
      ACC_SET: accNext = total;
      ACC_ADD: accNext = accNow + total;
      ACC_SUB: accNext = accNow - total;
      default: accNext = accNow;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg      <= '0;
      bReg      <= '0;
      signedReg <= 1'b0;
      partial   <= '0;
      hiReg     <= '0;
      loReg     <= '0;
      pipeData  <= '0;
      wbData    <= '0;
    end else begin
      if (strobe.loadOps) begin
        aReg      <= opA;
        bReg      <= opB;
        signedReg <= isSigned;
      end
      if (strobe.savePartial) partial <= prodWide;
      {hiReg, loReg} <= accNext;
      if (strobe.mulrCapture) pipeData <= total[W-1:0];
      if (strobe.wbFromPipe)  wbData <= pipeData;
      else if (strobe.moveHi) wbData <= hiReg;
      else if (strobe.moveLo) wbData <= loReg;
    end
  end

endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [2:0]        issueOp,
  input  logic              isSigned,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              issueReady,
  output logic              wbValid,
  output logic [DATA_W-1:0] wbData
);

  localparam int HALF_W = DATA_W / 2;

  logic       fitsHalf;
  macStrobe_t strobe;

  mac_size_detect #(.W(DATA_W), .HALF(HALF_W)) uDetect (
    .opB      (opB),
    .isSigned (isSigned),
    .fitsHalf (fitsHalf)
  );

  mac_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueOp    (issueOp),
    .fitsHalf   (fitsHalf),
    .issueReady (issueReady),
    .strobe     (strobe),
    .wbValid    (wbValid)
  );

  mac_datapath #(.W(DATA_W), .HALF(HALF_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .isSigned (isSigned),
    .strobe   (strobe),
    .wbData   (wbData)
  );

endmodule

// File: rtl/mac_hilo_checker.sv
module mac_hilo_checker (
  input logic       clk,
  input logic       rstN,
  input logic       issueValid,
  input logic [2:0] issueOp,
  input logic       issueReady,
  input logic       fitsHalf,
  input logic       wbValid
);

  logic mulPresented;
  logic movePresented;
  logic acceptMul;
  logic acceptMove;

  assign mulPresented  = (issueOp <= 3'd3);
  assign movePresented = (issueOp == 3'd4) || (issueOp == 3'd5);
  assign acceptMul     = issueValid && issueReady && mulPresented;
  assign acceptMove    = issueValid && issueReady && movePresented;

  AST_UNUSED_CODE_READY: assert property (@(posedge clk) disable iff (!rstN)
    (issueOp >= 3'd6) |-> issueReady); // R1

  AST_SHORT_REISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (acceptMul && fitsHalf) |=> (!mulPresented || issueReady)); // R4

  AST_LONG_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (acceptMul && !fitsHalf) |=> (!mulPresented || !issueReady)); // R5

  AST_LONG_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    (acceptMul && !fitsHalf) |=> ##1 (!mulPresented || issueReady)); // R5

  AST_READ_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    acceptMove |=> wbValid); // R8

  AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    acceptMul |=> (!movePresented || !issueReady)); // R9

endmodule

bind mac_hilo_unit mac_hilo_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .issueOp    (issueOp),
  .issueReady (issueReady),
  .fitsHalf   (fitsHalf),
  .wbValid    (wbValid)
);

// File: tb/tb_mac_hilo_unit.sv
module tb_mac_hilo_unit;

  localparam logic [2:0] C_MULT = 3'd0;
  localparam logic [2:0] C_MADD = 3'd1;
  localparam logic [2:0] C_MSUB = 3'd2;
  localparam logic [2:0] C_MULR = 3'd3;
  localparam logic [2:0] C_MFHI = 3'd4;
  localparam logic [2:0] C_MFLO = 3'd5;

  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [2:0]  issueOp;
  logic        isSigned;
  logic [31:0] opA;
  logic [31:0] opB;
  logic        issueReady;
  logic        wbValid;
  logic [31:0] wbData;

  always #2 clk = ~clk;   // 250 MHz

  mac_hilo_unit dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .isSigned(isSigned), .opA(opA), .opB(opB),
    .issueReady(issueReady), .wbValid(wbValid), .wbData(wbData)
  );

  typedef struct {int edgeNo; logic [31:0] data;} wbItem_t;

  int          vectors  = 0;
  int          misses   = 0;
  int          cyc      = 0;
  int          multFree = 0;
  int          moveFree = 0;
  bit          finished = 0;
  logic [63:0] accM     = '0;
  wbItem_t     wbQ[$];

  function automatic logic [63:0] refProduct(logic s, logic [31:0] a, logic [31:0] b);
    logic [63:0] wa, wb;
    wa = s ? {{32{a[31]}}, a} : {32'b0, a};
    wb = s ? {{32{b[31]}}, b} : {32'b0, b};
    return wa * wb;
  endfunction

  // R6: short second operand
  function automatic bit refShort(logic s, logic [31:0] b);
    if (s) return ($signed(b) >= -32768) && ($signed(b) <= 32767);
    return b <= 32'd65535;
  endfunction

  task automatic note(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic checkReady();
    bit exp;
    if (issueOp <= C_MULR)                          exp = (cyc + 1 >= multFree);
    else if (issueOp == C_MFHI || issueOp == C_MFLO) exp = (cyc + 1 >= moveFree);
    else                                            exp = 1'b1;
    note(issueReady === exp, "R1 R4 R5 R9 issueReady", 64'(issueReady), 64'(exp));
  endtask

  task automatic checkWb();
    bit          expV = 1'b0;
    logic [31:0] expD = '0;
    for (int i = wbQ.size() - 1; i >= 0; i--) begin
      if (wbQ[i].edgeNo <= cyc) begin
        if (wbQ[i].edgeNo == cyc) begin expV = 1'b1; expD = wbQ[i].data; end
        wbQ.delete(i);
      end
    end
    note(wbValid === expV, "R7 R8 wbValid", 64'(wbValid), 64'(expV));
    if (expV) note(wbData === expD, "R2 R3 R7 R8 wbData", 64'(wbData), 64'(expD));
  endtask

  task automatic step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    checkWb();
  endtask

  task automatic modelAccept(int e);
    logic [63:0] p;
    int          rate;
    p    = refProduct(isSigned, opA, opB);
    rate = refShort(isSigned, opB) ? 1 : 2;
    case (issueOp)
      C_MULT, C_MADD, C_MSUB: begin
        if (issueOp == C_MULT)      accM = p;
        else if (issueOp == C_MADD) accM = accM + p;
        else                        accM = accM - p;
        multFree = e + rate;
        if (e + rate + 1 > moveFree) moveFree = e + rate + 1;
      end
      C_MULR: begin
        wbQ.push_back('{e + rate + 1, p[31:0]});
        multFree = e + rate;
        if (e + rate + 2 > moveFree) moveFree = e + rate + 2;
      end
      C_MFHI: wbQ.push_back('{e, accM[63:32]});
      C_MFLO: wbQ.push_back('{e, accM[31:0]});
      default: ;
    endcase
  endtask

  task automatic doIssue(logic [2:0] op, logic s, logic [31:0] a, logic [31:0] b);
    issueOp = op; isSigned = s; opA = a; opB = b; issueValid = 1'b1;
    forever begin
      #1;
      checkReady();
      if (issueReady) begin
        modelAccept(cyc + 1);
        step();
        break;
      end
      step();
    end
    issueValid = 1'b0;
    issueOp    = C_MULT;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      #1;
      checkReady();
      step();
    end
  endtask

  task automatic readPair();
    doIssue(C_MFHI, 1'b0, '0, '0);
    doIssue(C_MFLO, 1'b0, '0, '0);
    idle(1);
  endtask

  initial begin
    rstN = 1'b0; issueValid = 1'b0; issueOp = C_MULT; isSigned = 1'b0;
    opA = '0; opB = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    cyc  = 0;
    #1;
    // R10: reset state
    note(wbValid === 1'b0, "R10 wbValid after reset", 64'(wbValid), 64'd0);
    note(issueReady === 1'b1, "R10 ready for multiply", 64'(issueReady), 64'd1);
    issueOp = C_MFHI; #0.5;
    note(issueReady === 1'b1, "R10 ready for read", 64'(issueReady), 64'd1);
    issueOp = C_MULT;
    @(negedge clk); cyc++;
    readPair();                                        // R10 pair reads zero

    // R2 unsigned extremes
    doIssue(C_MULT, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    doIssue(C_MFHI, 1'b0, '0, '0);
    note(wbData === 32'hFFFF_FFFE, "R2 unsigned high word", 64'(wbData), 64'hFFFF_FFFE);
    doIssue(C_MFLO, 1'b0, '0, '0);
    note(wbData === 32'h0000_0001, "R2 unsigned low word", 64'(wbData), 64'h1);

    // R2 signed small
    doIssue(C_MULT, 1'b1, 32'hFFFF_FFFD, 32'd7);
    doIssue(C_MFHI, 1'b0, '0, '0);
    note(wbData === 32'hFFFF_FFFF, "R2 signed high word", 64'(wbData), 64'hFFFF_FFFF);
    doIssue(C_MFLO, 1'b0, '0, '0);
    note(wbData === 32'hFFFF_FFEB, "R2 signed low word", 64'(wbData), 64'hFFFF_FFEB);

    // R3 accumulate, subtract and wraparound
    doIssue(C_MADD, 1'b1, 32'd100, 32'd200);
    doIssue(C_MSUB, 1'b1, 32'h8000_0000, 32'h8000_0000);
    readPair();
    doIssue(C_MULT, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    doIssue(C_MADD, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    doIssue(C_MADD, 1'b0, 32'h0000_0002, 32'hFFFF_FFFF);
    readPair();

    // R4 R5 R6 operand-size boundaries
    foreach (bSigned[i]) begin
      doIssue(C_MADD, 1'b1, 32'h1234_5678, bSigned[i]);
      doIssue(C_MADD, 1'b1, 32'h0000_0003, bSigned[i]);
    end
    readPair();
    foreach (bUnsigned[i]) begin
      doIssue(C_MSUB, 1'b0, 32'h8765_4321, bUnsigned[i]);
      doIssue(C_MSUB, 1'b0, 32'h0000_0005, bUnsigned[i]);
    end
    readPair();

    // R7 multiply-to-register, short and long, pair untouched
    doIssue(C_MULR, 1'b1, 32'hFFFF_FFF0, 32'd3);
    doIssue(C_MULR, 1'b1, 32'h0001_0001, 32'h0010_0001);
    doIssue(C_MULR, 1'b0, 32'hDEAD_BEEF, 32'd65535);
    idle(4);
    readPair();

    // R1 unused codes change nothing
    doIssue(3'd6, 1'b1, 32'h1111_1111, 32'h2222_2222);
    doIssue(3'd7, 1'b0, 32'h3333_3333, 32'h4444_4444);
    readPair();

    // R9 reads right behind multiplies
    doIssue(C_MULT, 1'b0, 32'h0000_1000, 32'h0123_4567);
    doIssue(C_MFLO, 1'b0, '0, '0);
    doIssue(C_MULR, 1'b0, 32'h0000_0009, 32'h0000_0009);
    doIssue(C_MFHI, 1'b0, '0, '0);

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [2:0]  op;
      logic [31:0] a, b;
      op = 3'($urandom_range(0, 7));
      if (op >= 3'd6 && $urandom_range(0, 3) != 0) op = C_MADD;
      a = $urandom;
      case ($urandom_range(0, 3))
        0: b = $urandom;
        1: b = 32'($urandom_range(0, 65535));
        2: b = 32'hFFFF_8000 | 32'($urandom_range(0, 32767));
        default: b = 32'($urandom_range(32760, 32775)) ^ ($urandom_range(0, 1) ? 32'hFFFF_FFFF : 32'h0);
      endcase
      doIssue(op, 1'($urandom_range(0, 1)), a, b);
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(5);
    readPair();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  logic [31:0] bSigned[6]   = '{32'hFFFF_8000, 32'h0000_7FFF, 32'h0000_8000,
                                32'hFFFF_7FFF, 32'h0000_0000, 32'h8000_0000};
  logic [31:0] bUnsigned[5] = '{32'h0000_FFFF, 32'h0001_0000, 32'hFFFF_FFFF,
                                32'h0000_8000, 32'h0000_0001};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule